// File: doc/BRIEF.md
# Ingress Source Address Guard

This block sits on the ingress side of a switch and decides what happens to each arriving Ethernet frame after its source MAC address has been looked up in the forwarding table. For every frame it is given the ingress port number, whether the frame carries a VLAN tag, and the lookup outcome: hit or miss, the port stored in the entry, whether the entry is static, and the group bit of the stored address.

The group bit of a source address is always zero on the wire. The table reuses it in static entries as a "pinned" marker. The block looks for three kinds of breach, and any one of them is enough:

- a pinned address appearing on a port other than its own;
- an unknown address arriving on a port that may not learn;
- a frame whose tag status is banned on its ingress port.

One stored 2-bit policy then picks one of four outcomes: let the frame pass, drop it, send it to both the CPU and its destination, or send it to the CPU alone.

The decision is registered. It leaves through a valid/ready handshake one clock after the lookup is accepted.

Top module: `src_addr_guard`

## Requirements
- R1: After reset, `out_valid` is 0 and the stored policy is "off" (code 00), so a frame that breaches a rule is still passed.
- R2: With policy 00 no frame is dropped or copied to the CPU, whatever the lookup and configuration inputs are.
- R3: An entry is pinned only when `lk_static` and `lk_group_bit` are both 1. A hit on an entry that is not pinned never causes a port-move breach.
- R4: A hit on a pinned entry whose `lk_port` differs from `in_port` is a breach. The same entry seen on its own port is not a breach.
- R5: A miss on a port whose `cfg_no_learn` bit is set is a breach. A hit on that port is not a breach, and neither is a miss on a port that may learn.
- R6: An untagged frame (`in_tagged`=0) on a port with `cfg_ban_untagged` set is a breach, and so is a tagged frame on a port with `cfg_ban_tagged` set. A frame with the allowed tag status is not a breach.
- R7: Under policy 01 a breaching frame yields {`out_forward`,`out_to_cpu`,`out_to_dest`} = 000 (dropped).
- R8: Under policy 10 a breaching frame yields 111 (CPU copy plus normal delivery).
- R9: Under policy 11 a breaching frame yields 110 (CPU only).
- R10: A frame with no breach yields 101 under every policy.
- R11: A lookup accepted on a clock edge (`in_valid` and `in_ready` both high) raises `out_valid` at the next edge with its decision.
- R12: While `out_valid` is 1 and `out_ready` is 0, the decision is held unchanged and `in_ready` is 0.
- R13: Only the configuration bits indexed by `in_port` take part in the decision. The bits of every other port have no effect.
- R14: A policy written through `mode_we`/`mode_wdata` applies to lookups accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the stored policy |
| mode_wdata | input | 2 | New policy code: 00 off, 01 drop, 10 CPU+dest, 11 CPU only |
| in_valid | input | 1 | Lookup result and frame attributes are valid |
| in_ready | output | 1 | Block can accept a lookup this cycle |
| in_port | input | PORT_W (4) | Ingress port number |
| in_tagged | input | 1 | Frame carries a VLAN tag |
| lk_hit | input | 1 | Source address found in the table |
| lk_port | input | PORT_W (4) | Port stored in the matching entry |
| lk_static | input | 1 | Matching entry is static |
| lk_group_bit | input | 1 | Group bit of the stored address (pinned marker) |
| cfg_no_learn | input | NUM_PORTS (16) | Per-port: learning disabled |
| cfg_ban_untagged | input | NUM_PORTS (16) | Per-port: untagged frames banned |
| cfg_ban_tagged | input | NUM_PORTS (16) | Per-port: tagged frames banned |
| out_valid | output | 1 | Decision is valid |
| out_ready | input | 1 | Consumer accepts the decision |
| out_forward | output | 1 | 1 = frame kept, 0 = dropped |
| out_to_cpu | output | 1 | Copy frame to the CPU |
| out_to_dest | output | 1 | Deliver frame to its normal destination |

## Verification
The hardest state to reach is a held decision under backpressure while a different lookup waits at the input. The held decision must not change, and the waiting lookup must not be taken early. The bench stalls `out_ready` with a breaching frame in the output register and presents a non-breaching frame for several cycles. It then releases `out_ready` on the same cycle the waiting frame is still valid, so the release edge both drains the old decision and accepts the new one. The port-move check also needs the pinned marker, which hides in a bit that real source addresses never set. The stimulus therefore sets the static and group-bit inputs in each combination, and moves the entry between ports.

// File: rtl/secchk_pkg.sv
package secchk_pkg;

    typedef enum logic [1:0] {
        POL_OFF      = 2'b00,
        POL_DROP     = 2'b01,
        POL_CPU_DEST = 2'b10,
        POL_CPU_ONLY = 2'b11
    } policy_e;

    typedef struct packed {
        logic fwd;
        logic cpu;
        logic dest;
    } verdict_t;

    typedef struct packed {
        logic port_move;
        logic unknown_src;
        logic tag_rule;
    } breach_t;

    localparam verdict_t V_PASS = '{fwd: 1'b1, cpu: 1'b0, dest: 1'b1};
    localparam verdict_t V_DROP = '{fwd: 1'b0, cpu: 1'b0, dest: 1'b0};
    localparam verdict_t V_BOTH = '{fwd: 1'b1, cpu: 1'b1, dest: 1'b1};
    localparam verdict_t V_CPU  = '{fwd: 1'b1, cpu: 1'b1, dest: 1'b0};

    function automatic logic any_breach(breach_t b);
        return b.port_move | b.unknown_src | b.tag_rule;
    endfunction

    function automatic logic is_pinned(logic is_static, logic group_bit);
        return is_static & group_bit;
    endfunction

endpackage

// File: rtl/secchk_port_cfg.sv
module secchk_port_cfg #(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [PORT_W-1:0]    port,
    input  logic [NUM_PORTS-1:0] no_learn_vec,
    input  logic [NUM_PORTS-1:0] ban_untag_vec,
    input  logic [NUM_PORTS-1:0] ban_tag_vec,
    output logic                 no_learn,
    output logic                 ban_untag,
    output logic                 ban_tag
);
    logic [NUM_PORTS-1:0] sel;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_dec
        assign sel[g] = (port == PORT_W'(g));
    end

    assign no_learn  = |(sel & no_learn_vec);
    assign ban_untag = |(sel & ban_untag_vec);
    assign ban_tag   = |(sel & ban_tag_vec);

    always_comb begin
        assert ($onehot0(sel));
    end
endmodule

// File: rtl/secchk_breach_eval.sv
module secchk_breach_eval
    import secchk_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic [PORT_W-1:0] in_port,
    input  logic              in_tagged,
    input  logic              lk_hit,
    input  logic [PORT_W-1:0] lk_port,
    input  logic              lk_static,
    input  logic              lk_group_bit,
    input  logic              no_learn,
    input  logic              ban_untag,
    input  logic              ban_tag,
    output breach_t           breach
);
    logic pinned;
    assign pinned = is_pinned(lk_static, lk_group_bit);

    always_comb begin
        breach             = '0;
        breach.port_move   = lk_hit & pinned & (lk_port != in_port);
        breach.unknown_src = no_learn & ~lk_hit;
        breach.tag_rule    = (ban_untag & ~in_tagged) | (ban_tag & in_tagged);
    end
endmodule

// File: rtl/secchk_policy.sv
module secchk_policy
    import secchk_pkg::*;
(
    input  policy_e  policy,
    input  breach_t  breach,
    output verdict_t verdict
);
    always_comb begin
        verdict = V_PASS;
        if (any_breach(breach)) begin
            unique case (policy)
                POL_OFF:      verdict = V_PASS;
                POL_DROP:     verdict = V_DROP;
                POL_CPU_DEST: verdict = V_BOTH;
                POL_CPU_ONLY: verdict = V_CPU;
                default:      verdict = V_PASS;
            endcase
        end
    end
endmodule

// File: rtl/src_addr_guard.sv
module src_addr_guard
    import secchk_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_we,
    input  logic [1:0]           mode_wdata,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PORT_W-1:0]    in_port,
    input  logic                 in_tagged,
    input  logic                 lk_hit,
    input  logic [PORT_W-1:0]    lk_port,
    input  logic                 lk_static,
    input  logic                 lk_group_bit,
    input  logic [NUM_PORTS-1:0] cfg_no_learn,
    input  logic [NUM_PORTS-1:0] cfg_ban_untagged,
    input  logic [NUM_PORTS-1:0] cfg_ban_tagged,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_forward,
    output logic                 out_to_cpu,
    output logic                 out_to_dest
);
    policy_e  mode_q;
    verdict_t verdict_d, verdict_q;
    breach_t  breach;
    logic     no_learn, ban_untag, ban_tag;
    logic     take;

    secchk_port_cfg #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_cfg (
        .port          (in_port),
        .no_learn_vec  (cfg_no_learn),
        .ban_untag_vec (cfg_ban_untagged),
        .ban_tag_vec   (cfg_ban_tagged),
        .no_learn      (no_learn),
        .ban_untag     (ban_untag),
        .ban_tag       (ban_tag)
    );

    secchk_breach_eval #(.PORT_W(PORT_W)) u_eval (
        .in_port      (in_port),
        .in_tagged    (in_tagged),
        .lk_hit       (lk_hit),
        .lk_port      (lk_port),
        .lk_static    (lk_static),
        .lk_group_bit (lk_group_bit),
        .no_learn     (no_learn),
        .ban_untag    (ban_untag),
        .ban_tag      (ban_tag),
        .breach       (breach)
    );

    secchk_policy u_pol (
        .policy  (mode_q),
        .breach  (breach),
        .verdict (verdict_d)
    );

    assign in_ready = ~out_valid | out_ready;
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= POL_OFF;
            out_valid <= 1'b0;
            verdict_q <= '0;
        end else begin
            if (mode_we) mode_q <= policy_e'(mode_wdata);
            if (take) begin
                out_valid <= 1'b1;
                verdict_q <= verdict_d;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign out_forward = verdict_q.fwd;
    assign out_to_cpu  = verdict_q.cpu;
    assign out_to_dest = verdict_q.dest;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && mode_q == POL_OFF));

    p_off_r2: assert property (@(posedge clk) disable iff (rst)
        (take && mode_q == POL_OFF && !mode_we) |=> (out_forward && !out_to_cpu));

    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_forward) |-> (!out_to_cpu && !out_to_dest));

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(verdict_q)));
endmodule

// File: tb/sim_src_addr_guard.sv
module sim_src_addr_guard;
    logic        clk = 1'b0;
    logic        rst;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_wdata = 2'b00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_port = '0;
    logic        in_tagged = 1'b0;
    logic        lk_hit = 1'b0;
    logic [3:0]  lk_port = '0;
    logic        lk_static = 1'b0;
    logic        lk_group_bit = 1'b0;
    logic [15:0] cfg_no_learn = '0;
    logic [15:0] cfg_ban_untagged = '0;
    logic [15:0] cfg_ban_tagged = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_forward, out_to_cpu, out_to_dest;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    localparam logic [2:0] PASS = 3'b101, DROP = 3'b000, BOTH = 3'b111, CPU = 3'b110;

    always #5 clk = ~clk;

    src_addr_guard u0 (.*);

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %b exp %b", req, got, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic send(input string req, input logic [3:0] p, input logic tg,
                        input logic hit, input logic [3:0] lp, input logic st,
                        input logic gb, input logic [2:0] exp);
        logic pre;
        @(negedge clk);
        in_port = p; in_tagged = tg; lk_hit = hit; lk_port = lp;
        lk_static = st; lk_group_bit = gb; in_valid = 1'b1;
        pre = out_valid;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " latency R11"}, {pre, out_valid, 1'b0}, 3'b010);
        chk(req, {out_forward, out_to_cpu, out_to_dest}, exp);
    endtask

    task automatic t_reset;
        chk("R1 out_valid after reset", {2'b00, out_valid}, 3'b000);
        cfg_ban_untagged = 16'h0001;
        send("R1 default policy off", 4'd0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, PASS);
        cfg_ban_untagged = '0;
    endtask

    task automatic t_policy_off;
        cfg_no_learn = 16'h0004; cfg_ban_tagged = 16'h0004;
        send("R2 off, all breaches", 4'd2, 1'b1, 1'b0, 4'd9, 1'b1, 1'b1, PASS);
        send("R2 off, pinned moved", 4'd3, 1'b0, 1'b1, 4'd7, 1'b1, 1'b1, PASS);
        cfg_no_learn = '0; cfg_ban_tagged = '0;
    endtask

    task automatic t_pinned;
        set_mode(2'b01);
        send("R3 static no marker", 4'd1, 1'b0, 1'b1, 4'd5, 1'b1, 1'b0, PASS);
        send("R3 marker not static", 4'd1, 1'b0, 1'b1, 4'd5, 1'b0, 1'b1, PASS);
        send("R4 pinned moved", 4'd1, 1'b0, 1'b1, 4'd5, 1'b1, 1'b1, DROP);
        send("R4 pinned home port", 4'd5, 1'b0, 1'b1, 4'd5, 1'b1, 1'b1, PASS);
        send("R4 pinned miss", 4'd1, 1'b0, 1'b0, 4'd5, 1'b1, 1'b1, PASS);
    endtask

    task automatic t_learn;
        cfg_no_learn = 16'h0100;
        send("R5 no-learn miss", 4'd8, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, DROP);
        send("R5 no-learn hit", 4'd8, 1'b0, 1'b1, 4'd8, 1'b0, 1'b0, PASS);
        send("R5 learning port miss", 4'd9, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, PASS);
        cfg_no_learn = '0;
    endtask

    task automatic t_tag;
        cfg_ban_untagged = 16'h0800; cfg_ban_tagged = 16'h1000;
        send("R6 untagged banned", 4'd11, 1'b0, 1'b1, 4'd11, 1'b0, 1'b0, DROP);
        send("R6 tagged allowed", 4'd11, 1'b1, 1'b1, 4'd11, 1'b0, 1'b0, PASS);
        send("R6 tagged banned", 4'd12, 1'b1, 1'b1, 4'd12, 1'b0, 1'b0, DROP);
        send("R6 untagged allowed", 4'd12, 1'b0, 1'b1, 4'd12, 1'b0, 1'b0, PASS);
    endtask

    task automatic t_policies;
        send("R7 drop policy", 4'd11, 1'b0, 1'b1, 4'd11, 1'b0, 1'b0, DROP);
        set_mode(2'b10);
        send("R8 cpu+dest policy", 4'd11, 1'b0, 1'b1, 4'd11, 1'b0, 1'b0, BOTH);
        send("R10 clean under 10", 4'd11, 1'b1, 1'b1, 4'd11, 1'b0, 1'b0, PASS);
        set_mode(2'b11);
        send("R9 cpu-only policy", 4'd12, 1'b1, 1'b1, 4'd12, 1'b0, 1'b0, CPU);
        send("R10 clean under 11", 4'd12, 1'b0, 1'b1, 4'd12, 1'b0, 1'b0, PASS);
        set_mode(2'b00);
        send("R14 policy back to off", 4'd12, 1'b1, 1'b1, 4'd12, 1'b0, 1'b0, PASS);
        cfg_ban_untagged = '0; cfg_ban_tagged = '0;
    endtask

    task automatic t_port_select;
        set_mode(2'b01);
        cfg_no_learn = 16'hFFDF; cfg_ban_untagged = 16'hFFDF; cfg_ban_tagged = 16'hFFDF;
        send("R13 other ports ignored", 4'd5, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, PASS);
        send("R13 other ports ignored tagged", 4'd5, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, PASS);
        send("R13 neighbour port active", 4'd4, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0, DROP);
        cfg_no_learn = '0; cfg_ban_untagged = '0; cfg_ban_tagged = '0;
    endtask

    task automatic t_hold;
        @(negedge clk);
        out_ready = 1'b0;
        send("R12 first frame", 4'd1, 1'b0, 1'b1, 4'd6, 1'b1, 1'b1, DROP);
        in_port = 4'd6; in_tagged = 1'b0; lk_hit = 1'b1; lk_port = 4'd6;
        lk_static = 1'b1; lk_group_bit = 1'b1; in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R12 held valid / in_ready low", {out_valid, in_ready, 1'b0}, 3'b100);
            chk("R12 held decision", {out_forward, out_to_cpu, out_to_dest}, DROP);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 waiting frame taken on release", {out_valid, 2'b00}, 3'b100);
        chk("R12 second decision", {out_forward, out_to_cpu, out_to_dest}, PASS);
        @(posedge clk);
        @(negedge clk);
        chk("R12 drained", {out_valid, 2'b00}, 3'b000);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_policy_off();
        t_pinned();
        t_learn();
        t_tag();
        t_policies();
        t_port_select();
        t_hold();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog expired got running exp finished");
            report();
        end
    end
endmodule